// File: doc/BRIEF.md
# Bursty Packet Traffic Generator

This block is a synthesizable test-traffic source for a single edge node of a packet network. On a valid/ready interface it emits packet descriptors. Each descriptor holds the node's own source number, a destination picked at random among all `N` nodes, and a transmission length in slots. Internal linear feedback shift registers supply all of the randomness. Each random interval is approximated by a Bernoulli trial taken on every clock: a 16-bit pseudo-random value is compared against a programmed probability threshold.

Two arrival modes are available. In smooth mode an arrival trial runs on every cycle. In burst mode a two-state ON/OFF machine gates those trials, so arrivals happen only while ON. The length of each ON period and each OFF period is set by a separate random trial. Smooth mode is the degenerate case of burst mode in which the OFF state never occurs. The offered load follows from the arrival probability multiplied by the mean duration. The duration comes from a free-running renewal counter. This gives a geometric spread whose mean is set by its own threshold. A new arrival needs a free output slot. An arrival that finds the slot still occupied is discarded and counted. The seed is loaded at reset, which makes every run repeatable.

Top module: `traffic_gen`

## Requirements
- R1: After a synchronous reset, `pktValid` is 0, `dropCount` is 0 and `burstOn` is 1.
- R2: Once `pktValid` is high it stays high, and `pktDst` and `pktDur` stay unchanged, until a cycle in which `pktReady` is high.
- R3: An arrival in a cycle where the slot is occupied (`pktValid` high and `pktReady` low) adds exactly one to `dropCount`, which saturates at all ones, and does not change the held descriptor.
- R4: While the node is effectively ON, an arrival occurs in a cycle when the arrival random value is less than or equal to `arrThr`. `arrThr` = 0 gives no arrivals. `arrThr` = 0xFFFF gives an arrival on every cycle, so with `pktReady` held high a fresh descriptor is presented on every cycle.
- R5: `pktSrc` equals the parameter `NODE_ID`. `pktDst` always lies in 0..N-1, and over many packets every destination occurs with roughly equal frequency.
- R6: With `burstMode` = 1, an ON state goes OFF on a cycle whose switch random value is less than or equal to `offThr`, and an OFF state goes ON when that value is less than or equal to `onThr`. While OFF, no new descriptor appears. With `offThr` = 0xFFFF and `onThr` = 0 the node stays OFF. With `onThr` = 0xFFFF and `offThr` = 0 it stays ON.
- R7: With `burstMode` = 0, the node is ON on every cycle after the first edge in that mode, whatever `onThr` and `offThr` are.
- R8: A duration counter restarts at 1 on each cycle whose duration random value is less than or equal to `durThr`. Otherwise it increments, saturating at 2^DUR_W-1. Each descriptor captures this counter, so `pktDur` is never 0, is 1 when `durThr` = 0xFFFF, and climbs by one per cycle when `durThr` = 0.
- R9: Two runs started by a reset with the same `seed` and driven with the same inputs produce identical descriptor sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| seed | input | 16 | Seed for all random streams, sampled during reset |
| burstMode | input | 1 | 0 selects smooth arrivals, 1 selects ON/OFF gated arrivals |
| arrThr | input | 16 | Per-cycle arrival probability threshold |
| onThr | input | 16 | Per-cycle probability of leaving OFF |
| offThr | input | 16 | Per-cycle probability of leaving ON |
| durThr | input | 16 | Per-cycle probability of restarting the duration counter |
| pktReady | input | 1 | Consumer accepts the current descriptor |
| pktValid | output | 1 | Descriptor present |
| pktSrc | output | $clog2(N) | Source node number |
| pktDst | output | $clog2(N) | Destination node number |
| pktDur | output | DUR_W | Duration in slots |
| dropCount | output | CNT_W | Arrivals discarded because the slot was occupied |
| burstOn | output | 1 | Current ON/OFF state |

## Verification
The arrival, switch and duration thresholds are driven at their extremes (0 and 0xFFFF), which makes the random process deterministic. Under those settings the bench can tell a silenced source from one that fires on every cycle, and a node stuck OFF from one stuck ON. It can also tell a duration that restarts on every cycle from one that keeps climbing up to saturation. A stalled consumer with full-rate arrivals separates correct holding and drop counting from silent overwriting. A long full-rate run with N = 6 shows whether destinations are spread evenly over a node count that is not a power of two. Two runs from the same seed show whether the sequence is repeatable.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int RND_W = 16;

  typedef struct packed {
    logic load;   // capture a new descriptor
    logic drop;   // arrival lost, slot busy
  } tg_strobe_t;
endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SALT = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  output logic [W-1:0] value
);
  logic [W-1:0] mixed;
  assign mixed = seed ^ SALT[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)           value <= (mixed == '0) ? W'(1) : mixed;
    else if (value[0]) value <= (value >> 1) ^ TAPS[W-1:0];
    else               value <= value >> 1;
  end
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             burstMode,
  input  logic [RND_W-1:0] arrRnd,
  input  logic [RND_W-1:0] swRnd,
  input  logic [RND_W-1:0] arrThr,
  input  logic [RND_W-1:0] onThr,
  input  logic [RND_W-1:0] offThr,
  input  logic             pktReady,
  output logic             pktValid,
  output logic             onState,
  output tg_strobe_t       strobe
);
  logic onEff, arrival, slotFree;

  assign onEff    = !burstMode || onState;
  assign arrival  = onEff && (arrRnd <= arrThr);
  assign slotFree = !pktValid || pktReady;

  always_comb begin
    strobe.load = arrival && slotFree;
    strobe.drop = arrival && !slotFree;
  end

  always_ff @(posedge clk) begin
    if (rst)             onState <= 1'b1;
    else if (!burstMode) onState <= 1'b1;
    else if (onState)    onState <= !(swRnd <= offThr);
    else                 onState <= (swRnd <= onThr);
  end

  always_ff @(posedge clk) begin
    if (rst)              pktValid <= 1'b0;
    else if (strobe.load) pktValid <= 1'b1;
    else if (pktReady)    pktValid <= 1'b0;
  end

  // R2
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pktValid && !pktReady |=> pktValid);
  // R7
  smooth_on_chk: assert property (@(posedge clk) disable iff (rst)
    !burstMode |=> onState);
  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pktValid) |-> $past(onState || !burstMode));
  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (arrThr == '1) && onEff && slotFree |=> pktValid);
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
#(
  parameter int N       = 6,
  parameter int NODE_ID = 0,
  parameter int DUR_W   = 8,
  parameter int CNT_W   = 16,
  localparam int DST_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  tg_strobe_t       strobe,
  input  logic [RND_W-1:0] dstRnd,
  input  logic [RND_W-1:0] durRnd,
  input  logic [RND_W-1:0] durThr,
  input  logic             pktValid,
  input  logic             pktReady,
  output logic [DST_W-1:0] pktSrc,
  output logic [DST_W-1:0] pktDst,
  output logic [DUR_W-1:0] pktDur,
  output logic [CNT_W-1:0] dropCount
);
  localparam int PROD_W = RND_W + DST_W + 1;

  logic [DUR_W-1:0]  durCnt;
  logic [PROD_W-1:0] scaled;
  logic [DST_W-1:0]  dstPick;

  // scale the random value into 0..N-1 by multiply and keep the high part
  assign scaled  = PROD_W'(dstRnd) * PROD_W'(N);
  assign dstPick = scaled[RND_W +: DST_W];
  assign pktSrc  = DST_W'(NODE_ID);

  always_ff @(posedge clk) begin
    if (rst)                  durCnt <= DUR_W'(1);
    else if (durRnd <= durThr) durCnt <= DUR_W'(1);
    else if (durCnt != '1)    durCnt <= durCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pktDst <= '0;
      pktDur <= DUR_W'(1);
    end else if (strobe.load) begin
      pktDst <= dstPick;
      pktDur <= durCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 dropCount <= '0;
    else if (strobe.drop && dropCount != '1) dropCount <= dropCount + 1'b1;
  end

  // R5
  dst_range_chk: assert property (@(posedge clk) disable iff (rst)
    pktValid |-> (pktDst < DST_W'(N)));
  // R8
  dur_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    pktValid |-> (pktDur != '0));
  // R2
  desc_stable_chk: assert property (@(posedge clk) disable iff (rst)
    pktValid && !pktReady |=> $stable(pktDst) && $stable(pktDur));
  // R3
  drop_count_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.drop && (dropCount != '1) |=> dropCount == $past(dropCount) + 1'b1);
endmodule

// File: rtl/traffic_gen.sv
module traffic_gen
  import tg_pkg::*;
#(
  parameter int N       = 6,
  parameter int NODE_ID = 2,
  parameter int DUR_W   = 8,
  parameter int CNT_W   = 16,
  localparam int DST_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      seed,
  input  logic             burstMode,
  input  logic [15:0]      arrThr,
  input  logic [15:0]      onThr,
  input  logic [15:0]      offThr,
  input  logic [15:0]      durThr,
  input  logic             pktReady,
  output logic             pktValid,
  output logic [DST_W-1:0] pktSrc,
  output logic [DST_W-1:0] pktDst,
  output logic [DUR_W-1:0] pktDur,
  output logic [CNT_W-1:0] dropCount,
  output logic             burstOn
);
  localparam int NSTREAM = 4;  // 0 arrival, 1 on/off switch, 2 destination, 3 duration

  logic [RND_W-1:0] rnd [NSTREAM];
  tg_strobe_t       strobe;

  for (genvar i = 0; i < NSTREAM; i++) begin : g_rnd
    tg_lfsr #(
      .W   (RND_W),
      .TAPS(16'hB400),
      .SALT(16'hACE1 ^ 16'(i * 16'h3B97))
    ) u_lfsr (
      .clk  (clk),
      .rst  (rst),
      .seed (seed),
      .value(rnd[i])
    );
  end

  tg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .burstMode(burstMode),
    .arrRnd   (rnd[0]),
    .swRnd    (rnd[1]),
    .arrThr   (arrThr),
    .onThr    (onThr),
    .offThr   (offThr),
    .pktReady (pktReady),
    .pktValid (pktValid),
    .onState  (burstOn),
    .strobe   (strobe)
  );

  tg_datapath #(
    .N      (N),
    .NODE_ID(NODE_ID),
    .DUR_W  (DUR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dstRnd   (rnd[2]),
    .durRnd   (rnd[3]),
    .durThr   (durThr),
    .pktValid (pktValid),
    .pktReady (pktReady),
    .pktSrc   (pktSrc),
    .pktDst   (pktDst),
    .pktDur   (pktDur),
    .dropCount(dropCount)
  );
endmodule

// File: tb/traffic_gen_tb.sv
module traffic_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N       = 6;
  localparam int NODE_ID = 2;
  localparam int DUR_W   = 8;
  localparam int CNT_W   = 16;
  localparam int DST_W   = $clog2(N);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [15:0]      seed = 16'h1234;
  logic             burstMode = 1'b0;
  logic [15:0]      arrThr = 16'h0000;
  logic [15:0]      onThr = 16'h0000;
  logic [15:0]      offThr = 16'h0000;
  logic [15:0]      durThr = 16'hFFFF;
  logic             pktReady = 1'b1;
  logic             pktValid;
  logic [DST_W-1:0] pktSrc;
  logic [DST_W-1:0] pktDst;
  logic [DUR_W-1:0] pktDur;
  logic [CNT_W-1:0] dropCount;
  logic             burstOn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  traffic_gen #(.N(N), .NODE_ID(NODE_ID), .DUR_W(DUR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .seed(seed), .burstMode(burstMode),
    .arrThr(arrThr), .onThr(onThr), .offThr(offThr), .durThr(durThr),
    .pktReady(pktReady), .pktValid(pktValid), .pktSrc(pktSrc), .pktDst(pktDst),
    .pktDur(pktDur), .dropCount(dropCount), .burstOn(burstOn)
  );

  // fields: mode | arrThr | onThr | offThr | ready | cycles | expValid | expOn
  localparam int NV = 6;
  localparam logic [59:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 8'd6, 1'b0, 1'b1},  // R4 silenced
    {1'b0, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 8'd4, 1'b1, 1'b1},  // R4 full rate
    {1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1, 8'd6, 1'b0, 1'b0},  // R6 stuck OFF
    {1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 8'd4, 1'b1, 1'b1},  // R6 back ON
    {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1, 8'd5, 1'b1, 1'b1},  // R7 smooth ignores off
    {1'b1, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 8'd4, 1'b0, 1'b1}   // R6 ON but no arrivals
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [15:0] s);
    seed = s;
    rst  = 1'b1;
    repeat (2) @(negedge clk);
    rst  = 1'b0;
  endtask

  task automatic recordRun(input logic [15:0] s, output logic [DST_W+DUR_W-1:0] seq [8]);
    burstMode = 1'b0; arrThr = 16'hFFFF; durThr = 16'h4000; pktReady = 1'b1;
    doReset(s);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      seq[k] = {pktDst, pktDur};
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DST_W+DUR_W-1:0] runA [8];
    logic [DST_W+DUR_W-1:0] runB [8];
    int hist [N];
    int mism;
    int badStep;
    logic [CNT_W-1:0] d0;
    logic [DST_W-1:0] dst0;
    logic [DUR_W-1:0] dur0;
    logic [DUR_W-1:0] prevDur;

    // R1 reset state
    doReset(16'h1234);
    chk("R1 valid", pktValid, 0);
    chk("R1 dropCount", dropCount, 0);
    chk("R1 burstOn", burstOn, 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      burstMode = VEC[v][59];
      arrThr    = VEC[v][58:43];
      onThr     = VEC[v][42:27];
      offThr    = VEC[v][26:11];
      pktReady  = VEC[v][10];
      repeat (int'(VEC[v][9:2])) @(negedge clk);
      chk($sformatf("R4/R6/R7 vec%0d valid", v), pktValid, VEC[v][1]);
      chk($sformatf("R6/R7 vec%0d burstOn", v), burstOn, VEC[v][0]);
    end
    chk("R3 no drops with ready high", dropCount, 0);

    // R5 source field
    chk("R5 src", pktSrc, NODE_ID);

    // R8 duration restarts every cycle at threshold all ones
    burstMode = 1'b0; arrThr = 16'hFFFF; durThr = 16'hFFFF; pktReady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 dur at full threshold", pktDur, 1);

    // R8 duration climbs by one per cycle with threshold zero
    durThr = 16'h0000;
    repeat (3) @(negedge clk);
    prevDur = pktDur;
    badStep = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (pktDur != prevDur + 1'b1) badStep++;
      prevDur = pktDur;
    end
    chk("R8 dur step errors", badStep, 0);
    repeat (300) @(negedge clk);
    chk("R8 dur saturates", pktDur, 255);

    // R2/R3 stalled consumer
    pktReady = 1'b0;
    repeat (2) @(negedge clk);
    d0 = dropCount; dst0 = pktDst; dur0 = pktDur;
    repeat (10) @(negedge clk);
    chk("R3 drops counted", dropCount, d0 + 10);
    chk("R2 valid held", pktValid, 1);
    chk("R2 dst held", pktDst, dst0);
    chk("R2 dur held", pktDur, dur0);
    pktReady = 1'b1;

    // R5 destination spread over many packets
    durThr = 16'hFFFF;
    for (int i = 0; i < N; i++) hist[i] = 0;
    @(negedge clk);
    for (int k = 0; k < 3000; k++) begin
      if (pktValid && int'(pktDst) < N) hist[pktDst]++;
      @(negedge clk);
    end
    for (int i = 0; i < N; i++)
      chk($sformatf("R5 dest %0d in band", i), (hist[i] >= 350 && hist[i] <= 650), 1);

    // R9 repeatability
    recordRun(16'hBEEF, runA);
    recordRun(16'hBEEF, runB);
    mism = 0;
    for (int k = 0; k < 8; k++) if (runA[k] !== runB[k]) mism++;
    chk("R9 same seed same sequence", mism, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule